// File: doc/BRIEF.md
# Segmented Histogram Merge Engine

This block builds a code-hit histogram of an ADC that is characterised piecewise. The converter is driven by a series of short ramps, each lifted by a different offset. Each ramp covers only part of the code range. The block receives the resulting output codes one sample at a time, with a marker on the first sample of a ramp and another on its last sample. For each ramp it keeps a separate partial histogram.

Codes at the ends of a partial histogram are unreliable, because noise and offset error act most strongly there. When a ramp ends, the block therefore walks its partial histogram once, drops the two smallest and the two largest codes that were hit, and copies the remaining counts into a global histogram. The global histogram keeps the first value it receives for each code. After the ramp flagged as the last one, the block raises a done flag and a coverage flag, and offers a read port into the merged counts.

Top module: `hist_merge_engine`

## Requirements
- R1: While a segment is open, every sample with `smp_valid` high adds exactly one to the partial count of `smp_code`. A code hit h times in a segment whose count survives is read back as h.
- R2: A partial count stops at 2^CNT_W-1 and never wraps. With CNT_W=4, a code hit 20 times reads back as 15.
- R3: At the end of a segment, the two smallest and the two largest distinct hit codes are discarded. This holds whatever order the codes arrived in. Only hit codes strictly between the second smallest and the second largest are merged. A segment with at most four distinct hit codes merges nothing.
- R4: When a code survives in more than one segment, the merged count comes from the earliest of those segments. Later values for that code are ignored.
- R5: `busy` rises in the cycle after the edge that accepts `seg_end` and stays high for exactly 2^CODE_W cycles, one per code.
- R6: A sample presented with `seg_start` is the first sample of the new segment. A sample presented with `seg_end` is the last sample of the ending segment.
- R7: `merge_done` rises when `busy` falls after a segment that was closed with `seg_last` high. From then until reset, all markers and samples are ignored and the merged contents do not change.
- R8: `cov_err` is set together with `merge_done` exactly when some code in the span 2 to 2^CODE_W-3 has no merged count. The two codes at each end of the range cannot survive a trim and are not checked.
- R9: The read port has one cycle of latency. Once `merge_done` is high, `rd_data` and `rd_cov` give the merged count and a covered bit (1) for `rd_addr`. For an uncovered code, or before done, both read 0.
- R10: A synchronous reset clears all segment state and the global histogram and drives `busy`, `merge_done`, `cov_err`, `rd_data` and `rd_cov` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_start | input | 1 | Opens a segment (accepted only when idle) |
| seg_end | input | 1 | Closes the open segment and starts the merge scan |
| seg_last | input | 1 | Qualifies `seg_end`: this is the final segment |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | ADC output code of the sample |
| busy | output | 1 | Merge scan in progress |
| merge_done | output | 1 | All segments merged; read port live |
| cov_err | output | 1 | A checked code has no merged count |
| rd_addr | input | CODE_W | Code to read |
| rd_data | output | CNT_W | Merged count for `rd_addr` (registered) |
| rd_cov | output | 1 | `rd_addr` received a merged count (registered) |

## Verification
A segment marker and a sample can arrive in the same cycle. Every ramp in the bench carries its first hit on the `seg_start` cycle and its last hit on the `seg_end` cycle. This bounds whether an edge code becomes one of the trimmed extremes. The counts of the codes just inside the trim, read back after the merge, show whether those two samples were charged to the right segment. The merge scan and the first-wins write can also coincide with a code already present from an earlier segment. Overlapping ramps with different per-code hit counts show which segment won each shared code.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_SCAN,
    ST_DONE
  } hpm_state_e;
endpackage

// File: rtl/hpm_partial.sv
// Partial histogram of the open segment plus a tracker of the two
// smallest and two largest distinct codes hit so far.
module hpm_partial #(
  parameter int CODE_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic [CODE_W-1:0] inc_code,
  input  logic [CODE_W-1:0] rd_idx,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              rd_keep
);
  localparam int NCODES = 1 << CODE_W;
  localparam logic [CODE_W:0] NONE_LO = (CODE_W+1)'(NCODES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_mem [NCODES];
  logic [NCODES-1:0] touched;
  // low trackers hold codes, high trackers hold code+1 (0 = none)
  logic [CODE_W:0]   lo0, lo1, hi0p, hi1p;
  logic [CODE_W:0]   b_lo0, b_lo1, b_hi0p, b_hi1p, c_ext, c_p1, r_ext;
  logic              fresh;
  logic [CNT_W-1:0]  old_cnt, new_cnt;

  always_comb begin
    fresh   = clr | ~touched[inc_code];
    old_cnt = cnt_mem[inc_code];
    if (fresh)                new_cnt = CNT_W'(1);
    else if (old_cnt == CNT_MAX) new_cnt = CNT_MAX;
    else                      new_cnt = old_cnt + 1'b1;
    b_lo0  = clr ? NONE_LO : lo0;
    b_lo1  = clr ? NONE_LO : lo1;
    b_hi0p = clr ? '0 : hi0p;
    b_hi1p = clr ? '0 : hi1p;
    c_ext  = {1'b0, inc_code};
    c_p1   = c_ext + 1'b1;
    r_ext  = {1'b0, rd_idx};
  end

  always_ff @(posedge clk) begin
    if (inc) cnt_mem[inc_code] <= new_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched <= '0;
      lo0     <= NONE_LO;
      lo1     <= NONE_LO;
      hi0p    <= '0;
      hi1p    <= '0;
    end else begin
      if (clr) begin
        touched <= '0;
        lo0     <= NONE_LO;
        lo1     <= NONE_LO;
        hi0p    <= '0;
        hi1p    <= '0;
      end
      if (inc && fresh) begin
        touched[inc_code] <= 1'b1;
        if (c_ext < b_lo0) begin
          lo0 <= c_ext;
          lo1 <= b_lo0;
        end else if (c_ext < b_lo1) begin
          lo1 <= c_ext;
        end
        if (c_p1 > b_hi0p) begin
          hi0p <= c_p1;
          hi1p <= b_hi0p;
        end else if (c_p1 > b_hi1p) begin
          hi1p <= c_p1;
        end
      end
    end
  end

  assign rd_cnt  = cnt_mem[rd_idx];
  assign rd_keep = touched[rd_idx] && (r_ext > lo1) && ((r_ext + 1'b1) < hi1p);

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && touched[inc_code] && cnt_mem[inc_code] == CNT_MAX)
      |=> cnt_mem[$past(inc_code)] == CNT_MAX);

  // R3
  trk_order_chk: assert property (@(posedge clk) disable iff (rst)
    (lo0 <= lo1) && (hi0p >= hi1p));
endmodule

// File: rtl/hpm_global.sv
// Merged histogram: first write per code wins; registered read port.
module hpm_global #(
  parameter int CODE_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [CODE_W-1:0] wr_idx,
  input  logic [CNT_W-1:0]  wr_cnt,
  output logic              covered_now,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_cov
);
  localparam int NCODES = 1 << CODE_W;

  logic [CNT_W-1:0]  g_mem [NCODES];
  logic [NCODES-1:0] g_valid;
  logic              take, rd_hit;

  assign take        = wr_req & ~g_valid[wr_idx];
  assign covered_now = g_valid[wr_idx] | wr_req;
  assign rd_hit      = rd_en & g_valid[rd_addr];

  always_ff @(posedge clk) begin
    if (take) g_mem[wr_idx] <= wr_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_valid <= '0;
      rd_data <= '0;
      rd_cov  <= 1'b0;
    end else begin
      if (take) g_valid[wr_idx] <= 1'b1;
      rd_cov  <= rd_hit;
      rd_data <= rd_hit ? g_mem[rd_addr] : '0;
    end
  end

  // R4
  first_win_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && g_valid[wr_idx]) |=> g_mem[$past(wr_idx)] == $past(g_mem[wr_idx]));
endmodule

// File: rtl/hpm_seq.sv
// Segment sequencer: accumulate, scan, finish; coverage bookkeeping.
module hpm_seq
  import hpm_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_start,
  input  logic              seg_end,
  input  logic              seg_last,
  input  logic              smp_valid,
  input  logic              covered_now,
  output logic              clr,
  output logic              inc,
  output logic              busy,
  output logic [CODE_W-1:0] scan_idx,
  output logic              merge_done,
  output logic              cov_err
);
  localparam int NCODES = 1 << CODE_W;
  localparam logic [CODE_W-1:0] IDX_LAST = '1;
  localparam logic [CODE_W-1:0] SPAN_LO  = CODE_W'(2);
  localparam logic [CODE_W-1:0] SPAN_HI  = CODE_W'(NCODES - 3);

  hpm_state_e state;
  logic       last_q, hole, in_span;

  always_comb begin
    clr     = (state == ST_IDLE) & seg_start;
    inc     = smp_valid & ((state == ST_ACC) | clr);
    busy    = (state == ST_SCAN);
    in_span = (scan_idx >= SPAN_LO) && (scan_idx <= SPAN_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      scan_idx   <= '0;
      last_q     <= 1'b0;
      hole       <= 1'b0;
      merge_done <= 1'b0;
      cov_err    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (seg_start) state <= ST_ACC;
        ST_ACC: if (seg_end) begin
          state    <= ST_SCAN;
          scan_idx <= '0;
          last_q   <= seg_last;
          hole     <= 1'b0;
        end
        ST_SCAN: begin
          scan_idx <= scan_idx + 1'b1;
          if (last_q && in_span && !covered_now) hole <= 1'b1;
          if (scan_idx == IDX_LAST) begin
            state <= last_q ? ST_DONE : ST_IDLE;
            if (last_q) begin
              merge_done <= 1'b1;
              cov_err    <= hole | (in_span & ~covered_now);
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    merge_done |=> merge_done);

  // R7
  done_after_scan_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(merge_done) |-> $past(busy));

  // R8
  err_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cov_err |-> merge_done);

  // R5
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && merge_done));
endmodule

// File: rtl/hist_merge_engine.sv
module hist_merge_engine #(
  parameter int CODE_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_start,
  input  logic              seg_end,
  input  logic              seg_last,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              busy,
  output logic              merge_done,
  output logic              cov_err,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_cov
);
  logic              clr, inc, keep, covered_now;
  logic [CODE_W-1:0] scan_idx;
  logic [CNT_W-1:0]  p_cnt;

  hpm_seq #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst(rst), .seg_start(seg_start), .seg_end(seg_end),
    .seg_last(seg_last), .smp_valid(smp_valid), .covered_now(covered_now),
    .clr(clr), .inc(inc), .busy(busy), .scan_idx(scan_idx),
    .merge_done(merge_done), .cov_err(cov_err)
  );

  hpm_partial #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_part (
    .clk(clk), .rst(rst), .clr(clr), .inc(inc), .inc_code(smp_code),
    .rd_idx(scan_idx), .rd_cnt(p_cnt), .rd_keep(keep)
  );

  hpm_global #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_glob (
    .clk(clk), .rst(rst), .wr_req(busy & keep), .wr_idx(scan_idx),
    .wr_cnt(p_cnt), .covered_now(covered_now), .rd_en(merge_done),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_cov(rd_cov)
  );
endmodule

// File: tb/tb_hist_merge_engine.sv
`timescale 1ns/1ps
module tb_hist_merge_engine;
  localparam int CW = 6;
  localparam int WW = 4;
  localparam int N  = 1 << CW;
  localparam int MX = (1 << WW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic seg_start = 0, seg_end = 0, seg_last = 0, smp_valid = 0;
  logic [CW-1:0] smp_code = '0, rd_addr = '0;
  logic busy, merge_done, cov_err, rd_cov;
  logic [WW-1:0] rd_data;

  int total = 0, fails = 0;
  int pc [N]; bit tch [N]; int eg [N]; bit ev [N];

  always #2.5 clk = ~clk;

  hist_merge_engine #(.CODE_W(CW), .CNT_W(WW)) dut (
    .clk(clk), .rst(rst), .seg_start(seg_start), .seg_end(seg_end),
    .seg_last(seg_last), .smp_valid(smp_valid), .smp_code(smp_code),
    .busy(busy), .merge_done(merge_done), .cov_err(cov_err),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_cov(rd_cov)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin ev[i] = 0; eg[i] = 0; tch[i] = 0; pc[i] = 0; end
  endtask

  // one sample per cycle; model follows the accepted stream
  task automatic put(bit st, bit en, bit ls, int code, bit model);
    seg_start = st; seg_end = en; seg_last = ls; smp_valid = 1'b1;
    smp_code = CW'(code);
    if (model) begin
      if (st) for (int i = 0; i < N; i++) begin tch[i] = 0; pc[i] = 0; end
      pc[code] = tch[code] ? ((pc[code] < MX) ? pc[code] + 1 : MX) : 1;
      tch[code] = 1;
    end
    @(negedge clk);
    seg_start = 0; seg_end = 0; seg_last = 0; smp_valid = 0;
  endtask

  task automatic model_merge();
    int k, lo1, hi1;
    k = 0; lo1 = N; hi1 = -1;
    for (int c = 0; c < N; c++) if (tch[c]) begin k++; if (k == 2) lo1 = c; end
    if (k >= 5) begin
      k = 0;
      for (int c = N - 1; c >= 0; c--) if (tch[c]) begin k++; if (k == 2) hi1 = c; end
      for (int c = lo1 + 1; c < hi1; c++)
        if (tch[c] && !ev[c]) begin ev[c] = 1; eg[c] = pc[c]; end
    end
  endtask

  function automatic int exp_err();
    for (int c = 2; c <= N - 3; c++) if (!ev[c]) return 1;
    return 0;
  endfunction

  // ramp lo..hi (descending if dn), hits per code from base; sat code gets 20
  task automatic ramp(int lo, int hi, bit dn, int base, int sat, bit last);
    int nb, cnt, h, c, first;
    first = 1; cnt = 0;
    for (int j = 0; j <= hi - lo; j++) begin
      c = dn ? hi - j : lo + j;
      h = (c == sat) ? 20 : ((c + base) % 3) + 1;
      for (int r = 0; r < h; r++) begin
        // R6: last hit of the ramp is sent with the end marker
        put(first[0], (j == hi - lo) && (r == h - 1), last, c, 1'b1);
        first = 0;
      end
    end
    model_merge();
    nb = 0;
    while (busy) begin nb++; @(negedge clk); end
    chk("R5 busy length", nb, N);
    if (last) begin
      chk("R7 merge_done", merge_done, 1);
      chk("R8 cov_err", cov_err, exp_err());
    end else begin
      chk("R7 no early done", merge_done, 0);
    end
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < N; a++) begin
      rd_addr = CW'(a);
      @(negedge clk);
      chk({tag, " R9 rd_data R1 R3 R4 R6"}, rd_data, ev[a] ? eg[a] : 0);
      chk({tag, " R9 rd_cov"}, rd_cov, ev[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 merge_done", merge_done, 0);
    chk("R10 cov_err", cov_err, 0);
    rd_addr = CW'(5);
    @(negedge clk);
    chk("R10 rd_data", rd_data, 0);
    chk("R9 rd_cov before done", rd_cov, 0);

    // run A: overlapping ramps, full coverage, descending middle ramp
    ramp(0, 20, 0, 0, -1, 0);
    ramp(15, 40, 1, 1, 30, 0);
    ramp(35, 63, 0, 2, -1, 1);
    read_all("A");
    rd_addr = CW'(30);
    @(negedge clk);
    chk("R2 saturated count", rd_data, MX);

    // R7: a further segment after done must change nothing
    put(1, 0, 0, 10, 0);
    repeat (5) put(0, 0, 0, 10, 0);
    put(0, 1, 1, 10, 0);
    chk("R7 no scan after done", busy, 0);
    chk("R7 done held", merge_done, 1);
    read_all("A-post");

    // run B: tiny segment and a coverage gap
    do_reset();
    chk("R10 done cleared", merge_done, 0);
    put(1, 0, 0, 23, 1);
    put(0, 0, 0, 22, 1);
    put(0, 0, 0, 25, 1);
    put(0, 1, 0, 24, 1);
    model_merge();
    while (busy) @(negedge clk);
    ramp(0, 20, 1, 1, -1, 0);
    ramp(30, 63, 0, 0, -1, 1);
    chk("R8 gap flagged", cov_err, 1);
    read_all("B");
    rd_addr = CW'(23);
    @(negedge clk);
    chk("R3 tiny segment merged nothing", rd_cov, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule